// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits between the deframing stage of an infrared serial receiver and its receive buffer. The deframer gives it a byte stream and three markers: a frame-start strobe once the opening flag has been seen, a byte-valid strobe for each byte, and an end-of-frame marker on the last byte. Software supplies a programmable station address and an enable bit. The block looks at the first byte of each frame, which is the address, and makes one decision for the whole frame. The frame is either passed to the buffer in full (address, control and data bytes) or dropped until the next frame starts.

The all-ones address is a broadcast and always passes. While filtering is disabled, every frame passes. Software may rewrite the station address and the enable at any moment, even during reception. Both values are copied into shadow registers on each frame-start strobe, so a rewrite only takes effect from the following frame. The reset value of the address is not meaningful, and software must program it before it enables the receiver. Accepted bytes come out one cycle after they arrive, registered, with a last-byte flag. A one-cycle pulse marks each frame that is rejected.

Top module: `rx_frame_addr_filter`

## Requirements
- R1: After reset, `out_vld`, `out_last` and `drop_pulse` are low. Bytes that arrive before any frame-start strobe produce no output.
- R2: The first byte with `byte_vld` high after `frm_start` is the address. If it equals the captured station address and filtering is enabled, that byte and every later byte of the frame appear on `out_data` with `out_vld` high, exactly one clock after each input byte.
- R3: If the address neither matches nor is all ones while filtering is enabled, no byte of that frame is forwarded. `drop_pulse` is high for exactly one clock, one clock after the address byte.
- R4: An address byte of all ones (0xFF at the default width) is forwarded together with its frame, whatever the captured station address.
- R5: When the captured enable is low, every frame is forwarded whatever its address, and `drop_pulse` stays low.
- R6: `match_val` and `filt_en` are sampled only in a clock where `frm_start` is high. A change at any other time does not affect the frame in progress and applies from the next frame.
- R7: `frm_end` is sampled only together with `byte_vld` and marks that byte as the last one of the frame. A forwarded last byte comes out with `out_last` high. After the last byte, all bytes are ignored until the next `frm_start`.
- R8: A `frm_start` that arrives during a frame abandons that frame. Any byte presented in the same clock as `frm_start` is ignored. The next valid byte is treated as a new address.
- R9: A frame made of a single address byte that carries `frm_end` is forwarded, when it is accepted, as one byte with both `out_vld` and `out_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Frame-start strobe, one clock, after the opening flag |
| byte_vld | input | 1 | Input byte valid |
| byte_data | input | DATA_W | Input byte |
| frm_end | input | 1 | Last byte of frame, qualified by byte_vld |
| match_val | input | DATA_W | Programmed station address |
| filt_en | input | 1 | Address filtering enable |
| out_vld | output | 1 | Forwarded byte valid |
| out_data | output | DATA_W | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the last of the frame |
| drop_pulse | output | 1 | One-clock pulse per rejected frame |

## Verification
The bench builds the block with the default `DATA_W` of 8, so the broadcast address is 0xFF. Every broadcast, match and mismatch case can therefore be driven with exact byte values. Directed frames cover mid-frame rewrites of both the station address and the enable, an abort by a second frame start, and a one-byte frame. Together they reach each edge of the pass/drop decision and each path by which a frame ends.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_PASS = 2'd2,
    S_DROP = 2'd3
  } rxf_state_t;
endpackage

// File: rtl/rxf_shadow.sv
module rxf_shadow #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic [DATA_W-1:0] match_val,
  input  logic              filt_en,
  output logic [DATA_W-1:0] sh_val,
  output logic              sh_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_val <= '0;
      sh_en  <= 1'b0;
    end else if (frm_start) begin
      sh_val <= match_val;
      sh_en  <= filt_en;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> $stable(sh_val) && $stable(sh_en)); // R6
endmodule

// File: rtl/rxf_addr_cmp.sv
module rxf_addr_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] ref_val,
  input  logic              en,
  output logic              hit
);
  localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};

  always_comb begin
    hit = !en || (addr == ref_val) || (addr == BCAST);
  end
endmodule

// File: rtl/rxf_fsm.sv
module rxf_fsm
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              frm_end,
  input  logic              hit,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              drop_pulse
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  rxf_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      out_vld    <= 1'b0;
      out_last   <= 1'b0;
      drop_pulse <= 1'b0;
      out_data   <= '0;
    end else begin
      out_vld    <= 1'b0;
      out_last   <= 1'b0;
      drop_pulse <= 1'b0;
      if (byte_vld) out_data <= byte_data;
      if (frm_start) begin
        state <= S_ADDR;
      end else if (byte_vld) begin
        case (state)
          S_ADDR: begin
            if (hit) begin
              out_vld  <= 1'b1;
              out_last <= frm_end;
              state    <= frm_end ? S_IDLE : S_PASS;
            end else begin
              drop_pulse <= 1'b1;
              state      <= frm_end ? S_IDLE : S_DROP;
            end
          end
          S_PASS: begin
            out_vld  <= 1'b1;
            out_last <= frm_end;
            if (frm_end) state <= S_IDLE;
          end
          S_DROP: begin
            if (frm_end) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_DROP_EXCL: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> !out_vld); // R3
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (rst)
    (state == S_ADDR && byte_vld && !frm_start && byte_data == ALL_ONES) |=> out_vld); // R4
  AST_LAST_VLD: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_vld); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |=> !out_vld && !drop_pulse); // R7
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> !out_vld && !drop_pulse); // R8
endmodule

// File: rtl/rx_frame_addr_filter.sv
module rx_frame_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              frm_end,
  input  logic [DATA_W-1:0] match_val,
  input  logic              filt_en,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              drop_pulse
);
  logic [DATA_W-1:0] sh_val;
  logic              sh_en;
  logic              hit;

  rxf_shadow #(.DATA_W(DATA_W)) i_shadow (
    .clk(clk), .rst(rst), .frm_start(frm_start),
    .match_val(match_val), .filt_en(filt_en),
    .sh_val(sh_val), .sh_en(sh_en)
  );

  rxf_addr_cmp #(.DATA_W(DATA_W)) i_cmp (
    .addr(byte_data), .ref_val(sh_val), .en(sh_en), .hit(hit)
  );

  rxf_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .frm_end(frm_end), .hit(hit),
    .out_vld(out_vld), .out_data(out_data), .out_last(out_last),
    .drop_pulse(drop_pulse)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_vld && !out_last && !drop_pulse); // R1
endmodule

// File: tb/test_rx_frame_addr_filter.sv
module test_rx_frame_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 1'b0, byte_vld = 1'b0, frm_end = 1'b0, filt_en = 1'b0;
  logic [DATA_W-1:0] byte_data = '0, match_val = '0;
  logic out_vld, out_last, drop_pulse;
  logic [DATA_W-1:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_addr_filter #(.DATA_W(DATA_W)) i_rx_frame_addr_filter (
    .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .frm_end(frm_end), .match_val(match_val),
    .filt_en(filt_en), .out_vld(out_vld), .out_data(out_data),
    .out_last(out_last), .drop_pulse(drop_pulse)
  );

  // Drive one clock of input at a falling edge; return at the next falling
  // edge, when the registered response to this input is visible.
  task automatic cyc(input logic s, input logic v, input logic [7:0] d, input logic e);
    frm_start = s; byte_vld = v; byte_data = d; frm_end = e;
    @(negedge clk);
    frm_start = 1'b0; byte_vld = 1'b0; frm_end = 1'b0;
  endtask

  task automatic chk(input string req, input logic ev, input logic [7:0] ed,
                     input logic el, input logic edr);
    n_run++;
    if (out_vld !== ev || out_last !== el || drop_pulse !== edr ||
        (ev && out_data !== ed)) begin
      n_fail++;
      $display("FAIL %s: vld/data/last/drop = %b/%h/%b/%b expected %b/%h/%b/%b",
               req, out_vld, out_data, out_last, drop_pulse, ev, ed, el, edr);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset", 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h3C, 0); chk("R1 byte before frame", 0, 8'h00, 0, 0);
  endtask

  task automatic t_match;
    match_val = 8'h3C; filt_en = 1'b1;
    cyc(1, 0, 8'h00, 0); chk("R2 start", 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h3C, 0); chk("R2 addr", 1, 8'h3C, 0, 0);
    cyc(0, 1, 8'h11, 0); chk("R2 ctrl", 1, 8'h11, 0, 0);
    cyc(0, 1, 8'h22, 1); chk("R7 last", 1, 8'h22, 1, 0);
    cyc(0, 1, 8'h55, 0); chk("R7 after end", 0, 8'h00, 0, 0);
  endtask

  task automatic t_mismatch;
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'h3D, 0); chk("R3 addr dropped", 0, 8'h00, 0, 1);
    cyc(0, 1, 8'h11, 0); chk("R3 ctrl dropped", 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h22, 1); chk("R3 end dropped", 0, 8'h00, 0, 0);
  endtask

  task automatic t_bcast;
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'hFF, 0); chk("R4 broadcast", 1, 8'hFF, 0, 0);
    cyc(0, 1, 8'h77, 1); chk("R4 broadcast last", 1, 8'h77, 1, 0);
  endtask

  task automatic t_disable;
    filt_en = 1'b0;
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'h99, 0); chk("R5 filter off addr", 1, 8'h99, 0, 0);
    cyc(0, 1, 8'h01, 1); chk("R5 filter off last", 1, 8'h01, 1, 0);
    filt_en = 1'b1;
  endtask

  task automatic t_shadow;
    match_val = 8'h3C;
    cyc(1, 0, 8'h00, 0);
    match_val = 8'h77;
    cyc(0, 1, 8'h3C, 0); chk("R6 old value used", 1, 8'h3C, 0, 0);
    cyc(0, 1, 8'h02, 1); chk("R6 old value frame end", 1, 8'h02, 1, 0);
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'h3C, 1); chk("R6 new value applies", 0, 8'h00, 0, 1);
    match_val = 8'h3C;
    cyc(1, 0, 8'h00, 0);
    filt_en = 1'b0;
    cyc(0, 1, 8'h44, 1); chk("R6 enable held", 0, 8'h00, 0, 1);
    filt_en = 1'b1;
  endtask

  task automatic t_abort;
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'h3C, 0); chk("R8 first addr", 1, 8'h3C, 0, 0);
    cyc(1, 1, 8'h3C, 0); chk("R8 byte at start ignored", 0, 8'h00, 0, 0);
    cyc(0, 1, 8'h12, 0); chk("R8 new addr judged", 0, 8'h00, 0, 1);
    cyc(0, 1, 8'h13, 1); chk("R8 rest dropped", 0, 8'h00, 0, 0);
  endtask

  task automatic t_single;
    cyc(1, 0, 8'h00, 0);
    cyc(0, 1, 8'h3C, 1); chk("R9 single byte", 1, 8'h3C, 1, 0);
    cyc(0, 1, 8'h3C, 0); chk("R9 idle after", 0, 8'h00, 0, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_match();
    t_mismatch();
    t_bcast();
    t_disable();
    t_shadow();
    t_abort();
    t_single();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule